// File: doc/BRIEF.md
# Receive Output Squelch and Clock Fallback

This block sits on the byte-wide receive side of a 155 Mb/s SONET/SDH line transceiver. It takes recovered bytes that arrive at about 19.44 MHz, signalled by a one-cycle byte strobe. It also takes a loss-of-signal flag and a PLL lock flag. When the line is in alarm, the block zeroes the outgoing bytes and switches the output clock away from the recovered clock to a reference source. The clock switch is modelled as a select signal that changes only at byte boundaries. The block also drives two polarity controls: one for the receive output clock and one that picks the transmit data sampling edge.

A mode input chooses between pin control and register control. With pin control, a dedicated input picks the reference source. The squelch is always active and both polarities stay at their defaults. With register control, a small write-only register port supplies the reference pick, the two polarity inversions and a bit that disables squelch and fallback. The alarm inputs pass through a two-stage synchroniser before they take effect.

Top module: `rxout_squelch`

## Requirements
- R1: The alarm is `sig_lost` OR NOT `pll_locked`. It passes through two flip-flop stages before use. A byte strobed one cycle after the alarm changes still sees the old state. A byte strobed two or more cycles after the change sees the new state.
- R2: When the synchronised alarm is active and squelch is enabled, a strobed byte appears on `out_data` as 8'h00 and `clk_sel_ref` goes to 1.
- R3: When squelch is not in effect, a byte strobed by `rcv_en` appears unchanged on `out_data` one cycle later, `clk_sel_ref` is 0, and `out_valid` is high exactly in the cycle after each strobe.
- R4: `clk_sel_ref`, `ref_src` and `out_data` change only in the cycle after an `rcv_en` strobe. Between strobes they hold even when the alarm changes.
- R5: `ref_src` takes its value at each strobe. With `sw_mode`=0 it comes from `hw_ref_sel`. With `sw_mode`=1 it comes from bit 5 of the control register (address 0).
- R6: With `sw_mode`=1, bit 7 of the alarm register (address 10) set to 1 disables squelch and fallback, so bytes pass and `clk_sel_ref` is 0 during alarm. With `sw_mode`=0 this bit has no effect.
- R7: `out_clk_invert` is 1 only when `sw_mode`=1 and control register bit 2 is 1. It lags its inputs by one register stage.
- R8: `tx_sample_rising` is 0 (falling-edge sampling) when `sw_mode`=0. With `sw_mode`=1 it equals control register bit 3, one register stage later.
- R9: Synchronous reset clears both registers. It sets `out_data`=0, `out_valid`=0, `clk_sel_ref`=1, `ref_src`=0 and both polarity outputs to 0, and presets the synchroniser to alarm. Output stays squelched until lock is reported.
- R10: A write (`wr_en`=1) to any address other than 0 or 10 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rcv_en | input | 1 | Recovered byte strobe (one cycle per byte) |
| rcv_data | input | 8 | Recovered byte |
| sig_lost | input | 1 | Loss-of-signal flag, asynchronous |
| pll_locked | input | 1 | Receive PLL lock flag, asynchronous |
| sw_mode | input | 1 | 0 = pin control, 1 = register control |
| hw_ref_sel | input | 1 | Reference source pick under pin control |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| out_data | output | 8 | Conditioned output byte |
| out_valid | output | 1 | Output byte strobe |
| clk_sel_ref | output | 1 | 1 = output clock taken from reference source |
| ref_src | output | 1 | Which reference source is selected |
| out_clk_invert | output | 1 | Invert receive output clock |
| tx_sample_rising | output | 1 | 1 = sample transmit bytes on rising edge |

## Verification
Suppose the synchroniser holds a wrong state. The error shows on the next strobed byte as data that is zeroed or passed when it should not be, with `clk_sel_ref` disagreeing with the alarm history one cycle after that strobe. Suppose a register bit or the mode decode is wrong. The polarity outputs show it one cycle after the write or mode change. The reference pick and squelch disable show it in the cycle after the next byte. A select register that updates off the byte boundary appears as a change in `clk_sel_ref` during the idle settle window before any strobe.

// File: rtl/rxsq_pkg.sv
package rxsq_pkg;
  // bit positions inside the control register
  localparam int unsigned RXCLK_INV_BIT = 2;
  localparam int unsigned TXEDGE_INV_BIT = 3;
  localparam int unsigned REF_PICK_BIT = 5;
  // bit position inside the alarm register
  localparam int unsigned SQ_DISABLE_BIT = 7;
endpackage

// File: rtl/rxsq_sync.sv
module rxsq_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RESET_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RESET_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxsq_cfg.sv
module rxsq_cfg #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned ALARM_ADDR = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] alarm_q
);
  localparam logic [AW-1:0] CTRL_A  = AW'(CTRL_ADDR);
  localparam logic [AW-1:0] ALARM_A = AW'(ALARM_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      alarm_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == CTRL_A)  ctrl_q  <= wr_data;
      if (wr_addr == ALARM_A) alarm_q <= wr_data;
    end
  end
endmodule

// File: rtl/rxsq_out.sv
module rxsq_out #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_en,
  input  logic [DW-1:0] byte_in,
  input  logic          squelch,
  input  logic          src_in,
  input  logic          inv_req,
  input  logic          rise_req,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          clk_sel_ref,
  output logic          ref_src,
  output logic          out_clk_invert,
  output logic          tx_sample_rising
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_data         <= '0;
      out_valid        <= 1'b0;
      clk_sel_ref      <= 1'b1;
      ref_src          <= 1'b0;
      out_clk_invert   <= 1'b0;
      tx_sample_rising <= 1'b0;
    end else begin
      out_valid        <= byte_en;
      out_clk_invert   <= inv_req;
      tx_sample_rising <= rise_req;
      // data and clock source switch together on a byte boundary
      if (byte_en) begin
        out_data    <= squelch ? '0 : byte_in;
        clk_sel_ref <= squelch;
        ref_src     <= src_in;
      end
    end
  end
endmodule

// File: rtl/rxout_squelch.sv
module rxout_squelch #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned ALARM_ADDR = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rcv_en,
  input  logic [DW-1:0] rcv_data,
  input  logic          sig_lost,
  input  logic          pll_locked,
  input  logic          sw_mode,
  input  logic          hw_ref_sel,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          clk_sel_ref,
  output logic          ref_src,
  output logic          out_clk_invert,
  output logic          tx_sample_rising
);
  import rxsq_pkg::*;

  logic          alarm_raw, alarm_s, sq_allowed, squelch, src_pick, inv_req, rise_req;
  logic [DW-1:0] ctrl_q, alarm_q;

  assign alarm_raw = sig_lost | ~pll_locked;

  rxsq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(alarm_raw), .q(alarm_s)
  );

  rxsq_cfg #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR), .ALARM_ADDR(ALARM_ADDR)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .alarm_q(alarm_q)
  );

  // pin control keeps squelch always on; register control may disable it
  assign sq_allowed = ~sw_mode | ~alarm_q[SQ_DISABLE_BIT];
  assign squelch    = alarm_s & sq_allowed;
  assign src_pick   = sw_mode ? ctrl_q[REF_PICK_BIT] : hw_ref_sel;
  assign inv_req    = sw_mode & ctrl_q[RXCLK_INV_BIT];
  assign rise_req   = sw_mode & ctrl_q[TXEDGE_INV_BIT];

  rxsq_out #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .byte_en(rcv_en), .byte_in(rcv_data),
    .squelch(squelch), .src_in(src_pick), .inv_req(inv_req), .rise_req(rise_req),
    .out_data(out_data), .out_valid(out_valid), .clk_sel_ref(clk_sel_ref),
    .ref_src(ref_src), .out_clk_invert(out_clk_invert),
    .tx_sample_rising(tx_sample_rising)
  );
endmodule

// File: rtl/rxsq_chk.sv
module rxsq_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned ALARM_ADDR = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          rcv_en,
  input logic [DW-1:0] rcv_data,
  input logic          sw_mode,
  input logic          alarm_s,
  input logic          sq_allowed,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] alarm_q,
  input logic [DW-1:0] out_data,
  input logic          out_valid,
  input logic          clk_sel_ref,
  input logic          ref_src,
  input logic          out_clk_invert,
  input logic          tx_sample_rising
);
  localparam logic [AW-1:0] CTRL_A  = AW'(CTRL_ADDR);
  localparam logic [AW-1:0] ALARM_A = AW'(ALARM_ADDR);

  a_r2_zero_on_alarm: assert property (@(posedge clk) disable iff (rst)
    rcv_en && alarm_s && sq_allowed |=> out_data == '0 && clk_sel_ref);

  a_r3_pass_clean: assert property (@(posedge clk) disable iff (rst)
    rcv_en && !(alarm_s && sq_allowed) |=> out_data == $past(rcv_data) && !clk_sel_ref);

  a_r3_valid_on_strobe: assert property (@(posedge clk) disable iff (rst)
    rcv_en |=> out_valid);

  a_r3_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !rcv_en |=> !out_valid);

  a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
    !rcv_en |=> $stable(clk_sel_ref) && $stable(ref_src) && $stable(out_data));

  a_r7_hw_clk_polarity: assert property (@(posedge clk) disable iff (rst)
    !sw_mode |=> !out_clk_invert);

  a_r8_hw_falling_edge: assert property (@(posedge clk) disable iff (rst)
    !sw_mode |=> !tx_sample_rising);

  a_r10_other_addr: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_addr != CTRL_A && wr_addr != ALARM_A |=> $stable(ctrl_q) && $stable(alarm_q));
endmodule

bind rxout_squelch rxsq_chk #(.DW(DW), .AW(AW), .CTRL_ADDR(CTRL_ADDR), .ALARM_ADDR(ALARM_ADDR)) u_chk (
  .clk(clk), .rst(rst), .rcv_en(rcv_en), .rcv_data(rcv_data), .sw_mode(sw_mode),
  .alarm_s(alarm_s), .sq_allowed(sq_allowed), .wr_en(wr_en), .wr_addr(wr_addr),
  .ctrl_q(ctrl_q), .alarm_q(alarm_q), .out_data(out_data), .out_valid(out_valid),
  .clk_sel_ref(clk_sel_ref), .ref_src(ref_src), .out_clk_invert(out_clk_invert),
  .tx_sample_rising(tx_sample_rising)
);

// File: tb/sim_rxout_squelch.sv
module sim_rxout_squelch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rcv_en = 1'b0;
  logic [7:0] rcv_data = '0;
  logic sig_lost = 1'b0, pll_locked = 1'b0, sw_mode = 1'b0, hw_ref_sel = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] out_data;
  logic out_valid, clk_sel_ref, ref_src, out_clk_invert, tx_sample_rising;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {logic [7:0] d; logic rf; logic src; string req;} exp_t;
  exp_t sb[$];

  logic [7:0] m_ctrl = '0, m_alarm = '0;
  logic last_ref = 1'b1;

  always #2.5 clk = ~clk;

  rxout_squelch u0 (
    .clk(clk), .rst(rst), .rcv_en(rcv_en), .rcv_data(rcv_data), .sig_lost(sig_lost),
    .pll_locked(pll_locked), .sw_mode(sw_mode), .hw_ref_sel(hw_ref_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .out_data(out_data),
    .out_valid(out_valid), .clk_sel_ref(clk_sel_ref), .ref_src(ref_src),
    .out_clk_invert(out_clk_invert), .tx_sample_rising(tx_sample_rising)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic model_sq();
    return (sig_lost | ~pll_locked) & (~sw_mode | ~m_alarm[7]);
  endfunction

  function automatic logic model_src();
    return sw_mode ? m_ctrl[5] : hw_ref_sel;
  endfunction

  // driver: called at a negedge, strobes one byte, returns at the next negedge
  task automatic send_byte(input logic [7:0] d, input logic sq, input string req);
    exp_t e;
    e.d = sq ? 8'h00 : d; e.rf = sq; e.src = model_src(); e.req = req;
    sb.push_back(e);
    last_ref = sq;
    rcv_en = 1'b1; rcv_data = d;
    @(negedge clk);
    rcv_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 4'd0) m_ctrl = v;
    if (a == 4'd10) m_alarm = v;
    repeat (2) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        checks++; failures++;
        $display("FAIL R3 actual=unexpected_byte expected=none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.req, " data"}, out_data, e.d);
        chk({e.req, " clk_sel_ref"}, {7'b0, clk_sel_ref}, {7'b0, e.rf});
        chk({e.req, " ref_src"}, {7'b0, ref_src}, {7'b0, e.src});
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 out_data", out_data, 8'h00);
    chk("R9 clk_sel_ref", {7'b0, clk_sel_ref}, 8'h01);
    chk("R9 out_valid", {7'b0, out_valid}, 8'h00);
    chk("R9 out_clk_invert", {7'b0, out_clk_invert}, 8'h00);
    chk("R9 tx_sample_rising", {7'b0, tx_sample_rising}, 8'h00);
    chk("R9 ref_src", {7'b0, ref_src}, 8'h00);
    settle();
    send_byte(8'hA5, model_sq(), "R9 squelched until lock");
    // lock reported; select must hold until a byte arrives (R4)
    pll_locked = 1'b1;
    settle();
    chk("R4 hold before strobe", {7'b0, clk_sel_ref}, {7'b0, last_ref});
    send_byte(8'h3C, model_sq(), "R3 pass after lock");
    send_byte(8'hC3, model_sq(), "R3 back-to-back");
    // loss of signal in pin mode
    sig_lost = 1'b1;
    settle();
    chk("R4 hold on alarm", {7'b0, clk_sel_ref}, 8'h00);
    send_byte(8'h5A, model_sq(), "R2 zero on los");
    hw_ref_sel = 1'b1;
    send_byte(8'h11, model_sq(), "R5 pin source");
    // disable bit ignored in pin mode
    wr(4'd10, 8'h80);
    send_byte(8'h22, model_sq(), "R6 pin mode ignores disable");
    wr(4'd0, 8'h2C);
    chk("R7 pin mode no invert", {7'b0, out_clk_invert}, 8'h00);
    chk("R8 pin mode falling", {7'b0, tx_sample_rising}, 8'h00);
    // register mode
    sw_mode = 1'b1;
    hw_ref_sel = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 reg invert", {7'b0, out_clk_invert}, 8'h01);
    chk("R8 reg rising", {7'b0, tx_sample_rising}, 8'h01);
    send_byte(8'h77, model_sq(), "R6 disabled squelch passes");
    wr(4'd10, 8'h00);
    send_byte(8'h66, model_sq(), "R2 reg mode squelch");
    wr(4'd0, 8'h04);
    chk("R7 invert kept", {7'b0, out_clk_invert}, 8'h01);
    chk("R8 rising cleared", {7'b0, tx_sample_rising}, 8'h00);
    send_byte(8'h99, model_sq(), "R5 reg source bit5=0");
    // lock loss alone
    sig_lost = 1'b0; pll_locked = 1'b0;
    settle();
    send_byte(8'h48, model_sq(), "R1 lock loss squelches");
    pll_locked = 1'b1;
    settle();
    send_byte(8'h84, model_sq(), "R1 clean again");
    // R10 other addresses ignored
    wr(4'd2, 8'hFF);
    wr(4'd8, 8'hFF);
    wr(4'd11, 8'hFF);
    chk("R10 invert unchanged", {7'b0, out_clk_invert}, 8'h01);
    chk("R10 rising unchanged", {7'b0, tx_sample_rising}, 8'h00);
    sig_lost = 1'b1;
    settle();
    send_byte(8'hF0, 1'b1, "R10 disable bit untouched");
    // R1 synchroniser latency
    sig_lost = 1'b0;
    settle();
    send_byte(8'h0F, 1'b0, "R1 settled clean");
    sig_lost = 1'b1;
    @(negedge clk);
    send_byte(8'hAB, 1'b0, "R1 one cycle after alarm still old");
    send_byte(8'hCD, 1'b1, "R1 two cycles after alarm new");
    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R3 actual=%0d pending expected=0", sb.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule